// File: doc/BRIEF.md
# Prescaled Tick Timer

This block is a periodic tick counter for a system timer. Two slow time bases, a crystal-derived one near 32.768 kHz and an internal RC one near 115 kHz, reach the block as single-cycle strobes. Each strobe marks one edge of that source, already synchronised to the bus clock. A control register picks one source and gates it into a power-of-two prescaler. The prescaled ticks drive a counter that runs from zero up to a programmable limit and then wraps. Each wrap sets a sticky status flag. That flag, qualified by a mask, drives the interrupt output.

Software programs the block through a small word-addressed register port. The limit, the counter and the control word are treated as living in the slow domain. Every accepted write to one of them starts a busy window that lasts a fixed number of ticks of the selected source. Writes to those three registers during the window are dropped. Software polls the busy bit before it writes. The mask and the status flag are set and cleared by writing ones to separate addresses.

Top module: `rtc_tick_timer`

## Requirements
- R1: With the prescaler running, the counter advances once per 2^(PSEL+1) strobes of the selected source. PSEL is held in CTRL bits [11:8], so PSEL=0 divides by 2 and PSEL=15 divides by 65536.
- R2: CTRL bit 2 selects the source. A value of 1 takes strobes from `xtal_tick` and 0 takes them from `rc_tick`. Strobes on the source that is not selected have no effect on the prescaler, the counter or the busy window.
- R3: CTRL bit 1 (clock gate) lets strobes into the prescaler and CTRL bit 0 (run) allows counting. If either bit is 0 the count holds. The prescaler returns to zero whenever either bit is 0 and whenever an accepted CTRL write changes PSEL.
- R4: The counter steps from 0 up to TOP (address 1) and returns to 0 on the tick after it equals TOP, so one wrap period is TOP+1 prescaled ticks. The count reads at address 2.
- R5: An accepted write to CTRL (address 0), TOP (address 1) or VAL (address 2) sets the busy bit, CTRL bit 16. The bit stays set for 3 strobes of the selected source. Any write to those three addresses while busy is set is discarded.
- R6: An accepted write to address 2 loads the counter with the written value. The load takes priority over a tick in the same cycle.
- R7: Status bit 0 (address 6) is set on each wrap and stays set until a 1 is written to bit 0 of address 7. If a clear and a wrap fall in the same cycle, the flag remains set.
- R8: Writing a 1 to bit 0 of address 3 sets the mask bit and writing a 1 to bit 0 of address 4 clears it. The mask reads at address 5. `irq` is high exactly when both status and mask are 1.
- R9: After reset every register, the count, the busy bit, the status and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle strobe per edge of the crystal source |
| rc_tick | input | 1 | One-cycle strobe per edge of the RC source |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Wrap interrupt, status AND mask |

## Verification
On every cycle, assertions check the following:
- an accepted write raises busy;
- a write while busy leaves TOP unchanged;
- the prescaler sits at zero while it is gated;
- the count holds while stopped;
- each rise of the flag follows a cycle in which the count equalled TOP.

Only the bench scenarios can show the rest, namely:
- the exact division ratio and wrap period in cycles;
- that the unselected source is ignored;
- that loads land on the right value;
- the mask and clear behaviour seen at `irq`.

A cycle model in the bench compares every read port value and the interrupt output under random traffic.

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int CNT_W      = 32,
  parameter int BUSY_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_tick,
  input  logic        rc_tick,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PRE_W  = 16;
  localparam int BUSY_W = $clog2(BUSY_TICKS + 1);

  logic              run_q, gate_q, src_q;
  logic [3:0]        psel_q;
  logic [CNT_W-1:0]  top_q, cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [BUSY_W-1:0] busy_q;
  logic              stat_q, mask_q;

  logic src_tick, busy, accept, pre_on, pre_last, tick, wrap;
  logic [PRE_W:0] pre_lim;

  assign src_tick = src_q ? xtal_tick : rc_tick;
  assign busy     = busy_q != '0;
  assign accept   = bus_we && (bus_addr <= 3'd2) && !busy;
  assign pre_on   = run_q && gate_q;
  assign pre_lim  = ((PRE_W+1)'(1) << ({1'b0, psel_q} + 5'd1)) - (PRE_W+1)'(1);
  assign pre_last = pre_q == pre_lim[PRE_W-1:0];
  assign tick     = pre_on && src_tick && pre_last;
  assign wrap     = tick && (cnt_q == top_q);
  assign irq      = stat_q && mask_q;

  logic unused_ok;
  assign unused_ok = ^{bus_wdata[31:12], bus_wdata[7:3], pre_lim[PRE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; gate_q <= 1'b0; src_q <= 1'b0; psel_q <= '0;
    end else if (accept && bus_addr == 3'd0) begin
      run_q  <= bus_wdata[0];
      gate_q <= bus_wdata[1];
      src_q  <= bus_wdata[2];
      psel_q <= bus_wdata[11:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                                      pre_q <= '0;
    else if (accept && bus_addr == 3'd0 && bus_wdata[11:8] != psel_q) pre_q <= '0;
    else if (!pre_on)                                                pre_q <= '0;
    else if (src_tick)                                               pre_q <= pre_last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (accept && bus_addr == 3'd2) cnt_q <= bus_wdata[CNT_W-1:0];
    else if (tick)                        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           top_q <= '0;
    else if (accept && bus_addr == 3'd1) top_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                busy_q <= '0;
    else if (accept)           busy_q <= BUSY_W'(BUSY_TICKS);
    else if (busy && src_tick) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                          stat_q <= 1'b0;
    else if (wrap)                                       stat_q <= 1'b1;
    else if (bus_we && bus_addr == 3'd7 && bus_wdata[0]) stat_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                          mask_q <= 1'b0;
    else if (bus_we && bus_addr == 3'd3 && bus_wdata[0]) mask_q <= 1'b1;
    else if (bus_we && bus_addr == 3'd4 && bus_wdata[0]) mask_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {15'd0, busy, 4'd0, psel_q, 5'd0, src_q, gate_q, run_q};
      3'd1:    bus_rdata = 32'(top_q);
      3'd2:    bus_rdata = 32'(cnt_q);
      3'd5:    bus_rdata = {31'd0, mask_q};
      3'd6:    bus_rdata = {31'd0, stat_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_drop_top_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1 && busy) |=> $stable(top_q));
  assert_pre_idle_when_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_on && !(bus_we && bus_addr == 3'd0)) |=> pre_q == '0);
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(bus_we && bus_addr == 3'd2)) |=> $stable(cnt_q));
  assert_flag_rise_at_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(cnt_q == top_q));
endmodule

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xtal_tick = 1'b0, rc_tick = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] last_rd;

  always #5 clk = ~clk;

  rtc_tick_timer i_rtc_tick_timer (.clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick),
    .rc_tick(rc_tick), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // reference state
  logic m_run, m_gate, m_src, m_stat, m_mask;
  logic [3:0] m_psel;
  logic [31:0] m_top, m_cnt;
  int m_pre, m_busy;

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return (32'(m_busy != 0) << 16) | (32'(m_psel) << 8) |
                    (32'(m_src) << 2) | (32'(m_gate) << 1) | 32'(m_run);
      3'd1: return m_top;
      3'd2: return m_cnt;
      3'd5: return 32'(m_mask);
      3'd6: return 32'(m_stat);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_gate = 0; m_src = 0; m_stat = 0; m_mask = 0;
      m_psel = 0; m_top = 0; m_cnt = 0; m_pre = 0; m_busy = 0;
    end else begin
      logic st, acc, pt, wr;
      st  = m_src ? xtal_tick : rc_tick;
      acc = bus_we && bus_addr <= 3'd2 && m_busy == 0;
      pt = 0;
      if (!(m_run && m_gate)) m_pre = 0;
      else if (st) begin
        if (m_pre == (1 << (int'(m_psel) + 1)) - 1) begin m_pre = 0; pt = 1; end
        else m_pre = m_pre + 1;
      end
      wr = pt && (m_cnt == m_top);
      if (pt) m_cnt = wr ? 32'd0 : m_cnt + 32'd1;
      if (acc && bus_addr == 3'd2) m_cnt = bus_wdata;
      if (acc && bus_addr == 3'd1) m_top = bus_wdata;
      if (acc && bus_addr == 3'd0) begin
        if (bus_wdata[11:8] != m_psel) m_pre = 0;
        m_run = bus_wdata[0]; m_gate = bus_wdata[1]; m_src = bus_wdata[2];
        m_psel = bus_wdata[11:8];
      end
      if (acc) m_busy = 3;
      else if (m_busy != 0 && st) m_busy = m_busy - 1;
      if (bus_we && bus_addr == 3'd7 && bus_wdata[0]) m_stat = 0;
      if (wr) m_stat = 1;
      if (bus_we && bus_addr == 3'd3 && bus_wdata[0]) m_mask = 1;
      else if (bus_we && bus_addr == 3'd4 && bus_wdata[0]) m_mask = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R5";
      3'd2:       return "R4";
      3'd5:       return "R8";
      default:    return "R7";
    endcase
  endfunction

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic xt, input logic rc, input string tag);
    bus_we = we; bus_addr = a; bus_wdata = d; xtal_tick = xt; rc_tick = rc;
    #1;
    last_rd = bus_rdata;
    chk(tag == "" ? tag_of(a) : tag, bus_rdata, ref_read(a));
    chk("R8", 32'(irq), 32'(m_stat && m_mask));
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 3'd0, 32'd0, 1'b1, 1'b1, "R5");
      if (last_rd[16] == 1'b0) break;
    end
  endtask

  initial begin
    int prev, rise_at, gap;
    logic [31:0] held;
    logic clr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) step(1'b0, 3'(a), 32'd0, 1'b0, 1'b0, "R9");

    // R5: second TOP write during busy is dropped
    step(1'b1, 3'd1, 32'd9, 1'b0, 1'b0, "R5");
    step(1'b1, 3'd1, 32'd4, 1'b0, 1'b0, "R5");
    wait_idle();
    step(1'b0, 3'd1, 32'd0, 1'b0, 1'b0, "R5");
    chk("R5", last_rd, 32'd9);

    // R1/R4: TOP=2, PSEL=1 -> wrap every 12 strobes
    step(1'b1, 3'd1, 32'd2, 1'b0, 1'b0, "R5");
    wait_idle();
    step(1'b1, 3'd3, 32'd1, 1'b0, 1'b0, "R8");
    step(1'b1, 3'd0, 32'h107, 1'b0, 1'b0, "R5");
    prev = 0; rise_at = -1; gap = 0; clr = 0;
    for (int i = 0; i < 60; i++) begin
      step(clr, clr ? 3'd7 : 3'd6, 32'd1, 1'b1, 1'b0, "R7");
      if (clr) clr = 0;
      else begin
        if (last_rd[0] && prev == 0) begin
          if (rise_at >= 0 && gap == 0) gap = i - rise_at;
          rise_at = i; clr = 1;
        end
        prev = int'(last_rd[0]);
        if (clr) prev = 0;
      end
    end
    chk("R1", 32'(gap), 32'd12);

    // R2: strobes of the unselected source do nothing
    step(1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R2");
    held = last_rd;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 3'd2, 32'd0, 1'b0, 1'b1, "R2");
      chk("R2", last_rd, held);
    end

    // R3: clock gate low freezes the count
    wait_idle();
    step(1'b1, 3'd0, 32'h105, 1'b0, 1'b0, "R3");
    step(1'b0, 3'd2, 32'd0, 1'b1, 1'b0, "R3");
    held = last_rd;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 3'd2, 32'd0, 1'b1, 1'b0, "R3");
      chk("R3", last_rd, held);
    end

    // R6: load VAL while stopped
    wait_idle();
    step(1'b1, 3'd0, 32'h0, 1'b0, 1'b0, "R6");
    wait_idle();
    step(1'b1, 3'd2, 32'd5, 1'b0, 1'b0, "R6");
    wait_idle();
    step(1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R6");
    chk("R6", last_rd, 32'd5);

    // random traffic against the reference
    void'($urandom(32'd2718));
    for (int i = 0; i < 20000; i++) begin
      logic we;
      logic [2:0] a;
      logic [31:0] d;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 8);
      case (a)
        3'd0: d = {20'd0, 4'(($urandom % 5 == 0) ? $urandom % 16 : $urandom % 3),
                   5'd0, 1'($urandom), 2'(($urandom % 4 == 0) ? $urandom : 3)};
        3'd1, 3'd2: d = $urandom % 16;
        default: d = {31'd0, 1'(($urandom % 4) != 0)};
      endcase
      step(we, a, d, 1'($urandom), ($urandom % 3) == 0, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule